// File: doc/BRIEF.md
# Sampled Reuse Distance Sampler

This block observes the access stream of a last-level cache and measures the reuse distance of a sparse sample of those accesses. Each access brings a byte address, the program counter of the instruction behind it, and a valid strobe. A period counter picks one valid access in every sampling period and stores its cache-line address and program counter in a small circular store. Every valid access is then looked up across all live entries of that store by line address.

When the lookup finds a live entry, the block retires that entry. It then reports the entry's program counter together with a coarse reuse distance. The distance is never counted access by access. It comes from the entry's age, which is the number of sampling pushes made since the entry went in. That age is halved, so two sampling periods make one distance unit. A predictor further down the pipeline consumes the one-cycle update strobe, the program counter and the 4-bit distance.

With the default parameters there are 32 entries and a period of 4096 accesses. The sampler can therefore see reuse distances up to 131072 accesses. The period and the depth are both parameters.

Top module: `reuse_sampler`

## Requirements
- R1: Only accesses with `acc_vld`=1 advance the period counter. The first valid access after reset is sampled, and after it every 2^PERIOD_LOG2-th valid access is sampled. Cycles with `acc_vld`=0 neither sample nor count.
- R2: Entries are matched on the line address `acc_addr[31:6]`. Two addresses that differ only in bits [5:0] match. Addresses that differ in bit 6 do not match.
- R3: The store keeps the DEPTH most recent samples. A push into a full store discards the oldest sample, which can then no longer produce an update.
- R4: Every valid access is looked up, whether or not it is sampled.
- R5: A lookup hit retires the matched entry. A second access to the same line then produces no update unless the line has been sampled again.
- R6: On a hit, `upd_pc` is the program counter stored with the entry. `upd_dist` is age >> 1, where age (0..DEPTH-1) is the number of pushes made between the entry's own push and the hitting access.
- R7: `upd_vld` rises in the cycle after the hitting access and lasts one cycle per hit. A miss, or a cycle with `acc_vld`=0, produces no update.
- R8: A given line is held by at most one live entry. A sampled access that hits replaces the old entry with a new one, so later hits measure age from the new push.
- R9: When an access is both sampled and looked up, the lookup sees the store as it was before the push. An access never hits its own new entry.
- R10: Reset clears `upd_vld`, `upd_pc` and `upd_dist`, empties the store and restarts the period counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_vld | input | 1 | Access strobe |
| acc_addr | input | ADDR_W (32) | Byte address of the access |
| acc_pc | input | PC_W (20) | Program counter of the access |
| upd_vld | output | 1 | Update strobe, one cycle per hit |
| upd_pc | output | PC_W (20) | Program counter of the retired entry |
| upd_dist | output | log2(DEPTH)-DIST_SHIFT (4) | Quantized reuse distance |

## Verification
The bench first targets the oldest-entry boundary. An entry that has aged 31 pushes must still hit and report distance 15, while one push more must make it vanish. A design with an off-by-one age or a faulty wrap of the write pointer reports a wrong distance or a stale hit here. It also covers the cases where an access both samples and hits the same line, and where an idle cycle carries a live address. A design that let the new entry answer its own lookup, or that counted or matched idle cycles, would emit spurious updates or sample the wrong accesses. Finally it checks that the byte-offset bits are ignored and that a hit retires the entry, so that repeated accesses do not keep reporting.

// File: rtl/reuse_sampler_pkg.sv
// Package: shared defaults and helpers for the reuse distance sampler.
// Assumes the store depth is a power of two so pointer arithmetic wraps.
package reuse_sampler_pkg;

    localparam int DEF_ADDR_W      = 32;
    localparam int DEF_LINE_OFF    = 6;
    localparam int DEF_PC_W        = 20;
    localparam int DEF_DEPTH       = 32;
    localparam int DEF_PERIOD_LOG2 = 12;
    localparam int DEF_DIST_SHIFT  = 1;

    // Convert an age in sampling periods into distance units.
    function automatic int unsigned age_to_units(input int unsigned age,
                                                 input int unsigned shift);
        return age >> shift;
    endfunction

endpackage

// File: rtl/rs_period_ctr.sv
// Module: rs_period_ctr
// Counts valid accesses modulo 2^PERIOD_LOG2 and flags the access that
// lands on count zero as the one to sample. Assumes PERIOD_LOG2 >= 1.
module rs_period_ctr #(
    parameter int PERIOD_LOG2 = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic acc_vld,
    output logic sample
);

    logic [PERIOD_LOG2-1:0] cnt_q;

    // Flag the access that opens a new period.
    always_comb begin
        sample = acc_vld && (cnt_q == '0);
    end

    // Advance the period count on every valid access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (acc_vld) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Two samples are never back to back when the period is at least two.
    assert_sample_gap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        sample |=> !sample);

endmodule

// File: rtl/rs_store.sv
// Module: rs_store
// Circular store of sampled line addresses and program counters.
// A push writes the slot at the write pointer and advances it, which
// overwrites the oldest sample once the store is full. A kill clears the
// valid bit of one slot; a push to the same slot in the same cycle wins.
module rs_store #(
    parameter int DEPTH = 32,
    parameter int TAG_W = 26,
    parameter int PC_W  = 20,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [TAG_W-1:0]             push_tag,
    input  logic [PC_W-1:0]              push_pc,
    input  logic                         kill,
    input  logic [IDX_W-1:0]             kill_idx,
    output logic [DEPTH-1:0][TAG_W-1:0]  tag_o,
    output logic [DEPTH-1:0][PC_W-1:0]   pc_o,
    output logic [DEPTH-1:0]             vld_o,
    output logic [IDX_W-1:0]             wptr_o
);

    logic [DEPTH-1:0][TAG_W-1:0] tag_q;
    logic [DEPTH-1:0][PC_W-1:0]  pc_q;
    logic [DEPTH-1:0]            vld_q;
    logic [IDX_W-1:0]            wptr_q;

    // Valid bits and write pointer: retire on kill, then claim on push.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q  <= '0;
            wptr_q <= '0;
        end else begin
            if (kill) begin
                vld_q[kill_idx] <= 1'b0;
            end
            if (push) begin
                vld_q[wptr_q] <= 1'b1;
                wptr_q        <= wptr_q + 1'b1;
            end
        end
    end

    // Payload storage, written only on push and left unreset.
    always_ff @(posedge clk) begin
        if (push) begin
            tag_q[wptr_q] <= push_tag;
            pc_q[wptr_q]  <= push_pc;
        end
    end

    assign tag_o  = tag_q;
    assign pc_o   = pc_q;
    assign vld_o  = vld_q;
    assign wptr_o = wptr_q;

    // A single cycle adds at most one live entry.
    assert_fill_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(vld_q) <= $past($countones(vld_q)) + 1);

    // A pushed slot is live afterwards, even if it was killed in the same cycle.
    assert_push_live_R9: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> vld_q[$past(wptr_q)]);

endmodule

// File: rtl/rs_search.sv
// Module: rs_search
// Fully associative lookup of a line address over every live slot.
// Slots are scanned from youngest to oldest, so the reported slot is
// the youngest match, together with its age in pushes.
module rs_search #(
    parameter int DEPTH = 32,
    parameter int TAG_W = 26,
    parameter int PC_W  = 20,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [DEPTH-1:0][TAG_W-1:0]  tag_i,
    input  logic [DEPTH-1:0][PC_W-1:0]   pc_i,
    input  logic [DEPTH-1:0]             vld_i,
    input  logic [IDX_W-1:0]             wptr_i,
    input  logic [TAG_W-1:0]             look_tag,
    output logic                         hit,
    output logic [IDX_W-1:0]             hit_idx,
    output logic [IDX_W-1:0]             hit_age,
    output logic [PC_W-1:0]              hit_pc
);

    logic [DEPTH-1:0] match_vec;

    // One comparator per slot.
    for (genvar s = 0; s < DEPTH; s++) begin : g_cmp
        assign match_vec[s] = vld_i[s] && (tag_i[s] == look_tag);
    end

    // Walk slots by age and keep the first (youngest) match.
    always_comb begin
        logic [IDX_W-1:0] slot;
        hit     = 1'b0;
        hit_idx = '0;
        hit_age = '0;
        for (int k = 0; k < DEPTH; k++) begin
            slot = wptr_i - IDX_W'(1) - IDX_W'(k);
            if (!hit && match_vec[slot]) begin
                hit     = 1'b1;
                hit_idx = slot;
                hit_age = IDX_W'(k);
            end
        end
        hit_pc = pc_i[hit_idx];
    end

    // No line is ever held by two live slots.
    assert_one_copy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match_vec));

endmodule

// File: rtl/reuse_sampler.sv
// Module: reuse_sampler (top)
// Samples one access per period into a circular store, looks up every
// valid access against the store, retires the hit entry and emits a
// registered update carrying the stored PC and a halved age. Assumes
// DEPTH is a power of two and DIST_SHIFT < log2(DEPTH).
module reuse_sampler #(
    parameter int ADDR_W      = reuse_sampler_pkg::DEF_ADDR_W,
    parameter int LINE_OFF    = reuse_sampler_pkg::DEF_LINE_OFF,
    parameter int PC_W        = reuse_sampler_pkg::DEF_PC_W,
    parameter int DEPTH       = reuse_sampler_pkg::DEF_DEPTH,
    parameter int PERIOD_LOG2 = reuse_sampler_pkg::DEF_PERIOD_LOG2,
    parameter int DIST_SHIFT  = reuse_sampler_pkg::DEF_DIST_SHIFT
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                acc_vld,
    input  logic [ADDR_W-1:0]                   acc_addr,
    input  logic [PC_W-1:0]                     acc_pc,
    output logic                                upd_vld,
    output logic [PC_W-1:0]                     upd_pc,
    output logic [$clog2(DEPTH)-DIST_SHIFT-1:0] upd_dist
);

    localparam int TAG_W  = ADDR_W - LINE_OFF;
    localparam int IDX_W  = $clog2(DEPTH);
    localparam int DIST_W = IDX_W - DIST_SHIFT;

    logic                         sample;
    logic [TAG_W-1:0]             look_tag;
    logic [DEPTH-1:0][TAG_W-1:0]  st_tag;
    logic [DEPTH-1:0][PC_W-1:0]   st_pc;
    logic [DEPTH-1:0]             st_vld;
    logic [IDX_W-1:0]             st_wptr;
    logic                         hit;
    logic                         hit_ok;
    logic [IDX_W-1:0]             hit_idx;
    logic [IDX_W-1:0]             hit_age;
    logic [PC_W-1:0]              hit_pc;
    logic                         upd_vld_q;
    logic [PC_W-1:0]              upd_pc_q;
    logic [DIST_W-1:0]            upd_dist_q;

    assign look_tag = acc_addr[ADDR_W-1:LINE_OFF];
    wire unused_offset = ^acc_addr[LINE_OFF-1:0];
    assign hit_ok = acc_vld && hit;

    rs_period_ctr #(
        .PERIOD_LOG2(PERIOD_LOG2)
    ) u_ctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .acc_vld(acc_vld),
        .sample (sample)
    );

    rs_store #(
        .DEPTH(DEPTH),
        .TAG_W(TAG_W),
        .PC_W (PC_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (sample),
        .push_tag(look_tag),
        .push_pc (acc_pc),
        .kill    (hit_ok),
        .kill_idx(hit_idx),
        .tag_o   (st_tag),
        .pc_o    (st_pc),
        .vld_o   (st_vld),
        .wptr_o  (st_wptr)
    );

    rs_search #(
        .DEPTH(DEPTH),
        .TAG_W(TAG_W),
        .PC_W (PC_W)
    ) u_search (
        .clk     (clk),
        .rst_n   (rst_n),
        .tag_i   (st_tag),
        .pc_i    (st_pc),
        .vld_i   (st_vld),
        .wptr_i  (st_wptr),
        .look_tag(look_tag),
        .hit     (hit),
        .hit_idx (hit_idx),
        .hit_age (hit_age),
        .hit_pc  (hit_pc)
    );

    // Register the update: strobe every cycle, payload only on a hit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upd_vld_q  <= 1'b0;
            upd_pc_q   <= '0;
            upd_dist_q <= '0;
        end else begin
            upd_vld_q <= hit_ok;
            if (hit_ok) begin
                upd_pc_q   <= hit_pc;
                upd_dist_q <= DIST_W'(reuse_sampler_pkg::age_to_units(
                                  int'(hit_age), DIST_SHIFT));
            end
        end
    end

    assign upd_vld  = upd_vld_q;
    assign upd_pc   = upd_pc_q;
    assign upd_dist = upd_dist_q;

    // An update always follows a valid access.
    assert_upd_after_access_R7: assert property (@(posedge clk) disable iff (!rst_n)
        upd_vld |-> $past(acc_vld));

    // A hit retires its slot, so the slot is no longer live next cycle unless re-pushed.
    assert_hit_retires_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_ok && !(sample && hit_idx == st_wptr)) |=> !st_vld[$past(hit_idx)]);

endmodule

// File: tb/reuse_sampler_bench.sv
`timescale 1ns/1ps
module reuse_sampler_bench;

    localparam int PL = 2;  // period of 4 valid accesses

    typedef struct packed {
        logic        v;
        logic [31:0] a;
        logic [19:0] p;
        logic        ev;
        logic [19:0] epc;
        logic [3:0]  ed;
    } row_t;

    localparam int NROWS = 22;
    // Valid-access index n is sampled when n % 4 == 0 (R1).
    localparam row_t TBL [NROWS] = '{
        '{1'b1, 32'h1000, 20'h11, 1'b0, 20'h0,  4'd0}, // n0 sampled
        '{1'b1, 32'h2000, 20'h12, 1'b0, 20'h0,  4'd0}, // n1 miss
        '{1'b0, 32'h1000, 20'h15, 1'b0, 20'h0,  4'd0}, // idle live addr: R7, R1
        '{1'b1, 32'h1010, 20'h13, 1'b1, 20'h11, 4'd0}, // n2 offset ignored: R2, R6
        '{1'b1, 32'h1000, 20'h14, 1'b0, 20'h0,  4'd0}, // n3 retired: R5
        '{1'b0, 32'h3000, 20'h16, 1'b0, 20'h0,  4'd0}, // idle
        '{1'b1, 32'h3000, 20'h21, 1'b0, 20'h0,  4'd0}, // n4 sampled
        '{1'b1, 32'h3040, 20'h22, 1'b0, 20'h0,  4'd0}, // n5 bit 6 differs: R2
        '{1'b1, 32'h5000, 20'h30, 1'b0, 20'h0,  4'd0}, // n6
        '{1'b1, 32'h6000, 20'h30, 1'b0, 20'h0,  4'd0}, // n7
        '{1'b1, 32'h3000, 20'h23, 1'b1, 20'h21, 4'd0}, // n8 sample+hit: R9
        '{1'b1, 32'h7000, 20'h30, 1'b0, 20'h0,  4'd0}, // n9
        '{1'b1, 32'h7100, 20'h30, 1'b0, 20'h0,  4'd0}, // n10
        '{1'b1, 32'h7200, 20'h30, 1'b0, 20'h0,  4'd0}, // n11
        '{1'b1, 32'h8000, 20'h31, 1'b0, 20'h0,  4'd0}, // n12 sampled
        '{1'b1, 32'h9000, 20'h30, 1'b0, 20'h0,  4'd0}, // n13
        '{1'b1, 32'h9100, 20'h30, 1'b0, 20'h0,  4'd0}, // n14
        '{1'b1, 32'h9200, 20'h30, 1'b0, 20'h0,  4'd0}, // n15
        '{1'b1, 32'hA000, 20'h41, 1'b0, 20'h0,  4'd0}, // n16 sampled
        '{1'b1, 32'h3000, 20'h25, 1'b1, 20'h23, 4'd1}, // n17 age 2 from re-push: R8, R4
        '{1'b1, 32'h8000, 20'h26, 1'b1, 20'h31, 4'd0}, // n18 age 1: R4, R6
        '{1'b1, 32'hA000, 20'h27, 1'b1, 20'h41, 4'd0}  // n19 age 0
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_vld = 1'b0;
    logic [31:0] acc_addr = '0;
    logic [19:0] acc_pc = '0;
    logic        upd_vld;
    logic [19:0] upd_pc;
    logic [3:0]  upd_dist;

    int checks = 0;
    int failures = 0;
    int stray = 0;

    always #2.5 clk = ~clk;

    reuse_sampler #(.PERIOD_LOG2(PL)) u_reuse_sampler (
        .clk(clk), .rst_n(rst_n), .acc_vld(acc_vld), .acc_addr(acc_addr),
        .acc_pc(acc_pc), .upd_vld(upd_vld), .upd_pc(upd_pc), .upd_dist(upd_dist)
    );

    task automatic chk(input logic ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive one access at a negedge; outputs are read at the next negedge.
    task automatic step(input logic v, input logic [31:0] a, input logic [19:0] p);
        acc_vld  = v;
        acc_addr = a;
        acc_pc   = p;
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n   = 1'b0;
        acc_vld = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic expect_upd(input string req, input logic ev, input logic [19:0] epc,
                              input logic [3:0] ed);
        if (ev)
            chk(upd_vld && upd_pc == epc && upd_dist == ed, req,
                {39'd0, upd_vld, upd_pc, upd_dist}, {39'd0, 1'b1, epc, ed});
        else
            chk(!upd_vld, req, 64'(upd_vld), 64'd0);
    endtask

    initial begin
        #(200000 * 5);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        // R10: outputs cleared under reset
        chk(upd_vld == 1'b0 && upd_pc == '0 && upd_dist == '0, "R10 reset outputs",
            {39'd0, upd_vld, upd_pc, upd_dist}, 64'd0);
        rst_n = 1'b1;

        // Vector table
        for (int i = 0; i < NROWS; i++) begin
            step(TBL[i].v, TBL[i].a, TBL[i].p);
            expect_upd($sformatf("R7 table row %0d", i), TBL[i].ev, TBL[i].epc, TBL[i].ed);
        end

        // R10: a live entry and the counter are cleared by reset
        step(1'b1, 32'hB000, 20'h55);          // n20 sampled
        expect_upd("R10 pre-reset push", 1'b0, 20'h0, 4'd0);
        do_reset();
        step(1'b1, 32'hB000, 20'h56);          // n0 after reset, sampled, store empty
        expect_upd("R10 store emptied", 1'b0, 20'h0, 4'd0);
        step(1'b1, 32'hB000, 20'h57);          // n1 hits new entry: counter restarted
        expect_upd("R10 counter restarted", 1'b1, 20'h56, 4'd0);

        // R6: oldest age (31) still hits, distance 15
        do_reset();
        stray = 0;
        step(1'b1, 32'h0010_0000, 20'h50);
        for (int n = 1; n <= 124; n++) begin
            step(1'b1, 32'h4000_0000 + 32'(n << 6), 20'(n));
            if (upd_vld) stray++;
        end
        chk(stray == 0, "R4 no spurious hits on unique lines", 64'(stray), 64'd0);
        step(1'b1, 32'h0010_0000, 20'h51);
        expect_upd("R6 age 31 gives distance 15", 1'b1, 20'h50, 4'd15);

        // R3: one push more than the depth discards the oldest
        do_reset();
        stray = 0;
        step(1'b1, 32'h0010_0000, 20'h50);
        for (int n = 1; n <= 128; n++) begin
            step(1'b1, 32'h4000_0000 + 32'(n << 6), 20'(n));
            if (upd_vld) stray++;
        end
        chk(stray == 0, "R3 no spurious hits while filling", 64'(stray), 64'd0);
        step(1'b1, 32'h0010_0000, 20'h52);
        expect_upd("R3 oldest overwritten", 1'b0, 20'h0, 4'd0);
        step(1'b1, 32'h4000_0000 + 32'(4 << 6), 20'h53);
        expect_upd("R3 next oldest kept", 1'b1, 20'h4, 4'd15);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule